// File: doc/BRIEF.md
# Incrementing-Count Link Self-Test Pair

This block is a built-in self-test pair for a 16-bit parallel link. A generator on the transmit side emits, on every enabled cycle, a word made of consecutive values of an 8-bit running count, and flags that word as valid. The words travel through whatever loopback path the link offers and come back to a checker on the receive side. The checker waits for the start of the count, follows the sequence from there, and reports the result on two sticky flags: one that marks a mismatch and one that marks the end of the test.

The two halves have their own clock and their own synchronous active-high reset. Either half can be restarted without disturbing the other. The status flags clear only through the receive-side reset. Each word holds two count values, so one full sweep of the 8-bit count takes 128 words.

Top module: `incr_bist`

## Requirements
- R1: While its reset is high, the generator drives `tx_word_vld` low and its count returns to 0. While the receive reset is high, `rx_err` and `rx_done` are low and the checker goes back to searching for the start of the pattern.
- R2: Each enabled cycle makes one word valid on the next cycle. The low byte of that word (bits 7:0) is the count n and the high byte (bits 15:8) is n+1. The first word after reset is 16'h0100, and n grows by 2 on each enabled cycle. A cycle with `tx_en` low produces no valid word and leaves the count unchanged.
- R3: The count wraps from 16'hFFFE to 16'h0100 and keeps running without a pause.
- R4: Until the checker receives a valid word whose low byte is 16'h00, it compares nothing and both flags stay low.
- R5: The checker sets `rx_done`, with `rx_err` low, on the cycle after the 128th correct valid word. The words counted are the locking word 16'h0100 and every following word, up to and including 16'hFFFE.
- R6: After lock, a valid word that differs from the expected word sets both `rx_err` and `rx_done` on the next cycle. Both flags then stay high until the receive reset.
- R7: A cycle with `rx_vld` low is neither compared nor counted, whatever its data.
- R8: Once `rx_done` is set, both flags stop updating, so a mismatch that arrives after a clean sweep leaves `rx_err` low.
- R9: The transmit reset does not change the checker flags. The receive reset does not stop or restart the generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Generator clock |
| tx_rst | input | 1 | Generator synchronous reset, active high |
| tx_en | input | 1 | Produce one pattern word this cycle |
| tx_word | output | 16 | Pattern word toward the link |
| tx_word_vld | output | 1 | `tx_word` holds a pattern word |
| rx_clk | input | 1 | Checker clock |
| rx_rst | input | 1 | Checker synchronous reset, active high |
| rx_vld | input | 1 | `rx_word` holds a received word |
| rx_word | input | 16 | Word returned by the loopback path |
| rx_err | output | 1 | Sticky mismatch flag |
| rx_done | output | 1 | Sticky end-of-test flag |

## Verification
The hardest conditions to reach through the loop are the exact 128-word boundary and a mismatch that arrives after `rx_done` is already set. A correct generator never produces that late mismatch, and in loopback the boundary hides behind the path latency. For these cases the bench disconnects the loop and drives the checker inputs word by word. It sends 127 correct words and checks that `rx_done` is still low, then sends the last word, and after that a deliberately wrong one. Garbage words with `rx_vld` low are mixed into the same run. A single bit flipped in the loopback path, followed by a receive-only reset, covers error stickiness and the independence of the two resets.

// File: rtl/incr_bist_pkg.sv
package incr_bist_pkg;
    localparam int BIST_DATA_W  = 16;
    localparam int BIST_COUNT_W = 8;

    typedef enum logic [1:0] {
        CHK_HUNT = 2'd0,
        CHK_RUN  = 2'd1,
        CHK_HALT = 2'd2
    } chk_state_e;

    typedef struct packed {
        logic err;
        logic done;
    } chk_flags_t;
endpackage

// File: rtl/incr_lane_pack.sv
module incr_lane_pack #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic [CW-1:0] base,
    output logic [DW-1:0] word
);
    localparam int LANES = DW / CW;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign word[i*CW +: CW] = base + CW'(i);
        end
    endgenerate
endmodule

// File: rtl/incr_gen.sv
module incr_gen #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [DW-1:0] word,
    output logic          vld
);
    localparam int LANES = DW / CW;

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] next_word;

    incr_lane_pack #(.DW(DW), .CW(CW)) u_pack (
        .base(cnt_q),
        .word(next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            vld   <= 1'b0;
            word  <= '0;
        end else begin
            vld <= en;
            if (en) begin
                word  <= next_word;
                cnt_q <= cnt_q + CW'(LANES);
            end
        end
    end
endmodule

// File: rtl/incr_chk.sv
module incr_chk
    import incr_bist_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld,
    input  logic [DW-1:0] word,
    output chk_flags_t    flags
);
    localparam int LANES  = DW / CW;
    localparam int LAST_I = (1 << CW) - LANES;
    localparam logic [CW-1:0] LAST_BASE = CW'(LAST_I);

    chk_state_e    state_q;
    logic [CW-1:0] exp_q;
    logic [DW-1:0] exp_word;
    logic          match;
    logic          at_start;

    incr_lane_pack #(.DW(DW), .CW(CW)) u_pack (
        .base(exp_q),
        .word(exp_word)
    );

    assign match    = (word == exp_word);
    assign at_start = (word[CW-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CHK_HUNT;
            exp_q   <= '0;
            flags   <= '0;
        end else if (vld) begin
            case (state_q)
                CHK_HUNT: begin
                    if (at_start) begin
                        if (!match) begin
                            flags   <= '{err: 1'b1, done: 1'b1};
                            state_q <= CHK_HALT;
                        end else begin
                            exp_q   <= CW'(LANES);
                            state_q <= CHK_RUN;
                        end
                    end
                end
                CHK_RUN: begin
                    if (!match) begin
                        flags   <= '{err: 1'b1, done: 1'b1};
                        state_q <= CHK_HALT;
                    end else if (exp_q == LAST_BASE) begin
                        flags.done <= 1'b1;
                        state_q    <= CHK_HALT;
                    end else begin
                        exp_q <= exp_q + CW'(LANES);
                    end
                end
                default: state_q <= CHK_HALT;
            endcase
        end
    end
endmodule

// File: rtl/incr_bist.sv
module incr_bist
    import incr_bist_pkg::*;
#(
    parameter int DW = BIST_DATA_W,
    parameter int CW = BIST_COUNT_W
) (
    input  logic          tx_clk,
    input  logic          tx_rst,
    input  logic          tx_en,
    output logic [DW-1:0] tx_word,
    output logic          tx_word_vld,
    input  logic          rx_clk,
    input  logic          rx_rst,
    input  logic          rx_vld,
    input  logic [DW-1:0] rx_word,
    output logic          rx_err,
    output logic          rx_done
);
    chk_flags_t flags;

    incr_gen #(.DW(DW), .CW(CW)) u_gen (
        .clk (tx_clk),
        .rst (tx_rst),
        .en  (tx_en),
        .word(tx_word),
        .vld (tx_word_vld)
    );

    incr_chk #(.DW(DW), .CW(CW)) u_chk (
        .clk  (rx_clk),
        .rst  (rx_rst),
        .vld  (rx_vld),
        .word (rx_word),
        .flags(flags)
    );

    assign rx_err  = flags.err;
    assign rx_done = flags.done;
endmodule

// File: rtl/incr_bist_sva.sv
module incr_bist_sva #(
    parameter int DW = 16,
    parameter int CW = 8
) (
    input logic          tx_clk,
    input logic          tx_rst,
    input logic          tx_en,
    input logic [DW-1:0] tx_word,
    input logic          tx_word_vld,
    input logic          rx_clk,
    input logic          rx_rst,
    input logic          rx_err,
    input logic          rx_done
);
    // R1
    tx_reset_idle_chk: assert property (@(posedge tx_clk) tx_rst |=> !tx_word_vld);
    // R1
    rx_reset_clear_chk: assert property (@(posedge rx_clk) rx_rst |=> (!rx_err && !rx_done));
    // R2
    en_gives_word_chk: assert property (@(posedge tx_clk) disable iff (tx_rst) tx_en |=> tx_word_vld);
    // R2
    idle_no_word_chk: assert property (@(posedge tx_clk) disable iff (tx_rst) !tx_en |=> !tx_word_vld);
    // R2
    lane_step_chk: assert property (@(posedge tx_clk) disable iff (tx_rst)
        tx_word_vld |-> (tx_word[2*CW-1:CW] == tx_word[CW-1:0] + CW'(1)));
    // R6
    err_with_done_chk: assert property (@(posedge rx_clk) disable iff (rx_rst) rx_err |-> rx_done);
    // R6
    err_sticky_chk: assert property (@(posedge rx_clk) disable iff (rx_rst) rx_err |=> rx_err);
    // R6
    done_sticky_chk: assert property (@(posedge rx_clk) disable iff (rx_rst) rx_done |=> rx_done);
    // R8
    no_late_err_chk: assert property (@(posedge rx_clk) disable iff (rx_rst)
        (rx_done && !rx_err) |=> !rx_err);
endmodule

bind incr_bist incr_bist_sva #(.DW(DW), .CW(CW)) u_sva (
    .tx_clk     (tx_clk),
    .tx_rst     (tx_rst),
    .tx_en      (tx_en),
    .tx_word    (tx_word),
    .tx_word_vld(tx_word_vld),
    .rx_clk     (rx_clk),
    .rx_rst     (rx_rst),
    .rx_err     (rx_err),
    .rx_done    (rx_done)
);

// File: tb/incr_bist_test.sv
module incr_bist_test;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        tx_rst, rx_rst, tx_en;
    logic [15:0] tx_word;
    logic        tx_word_vld;
    logic        rx_vld;
    logic [15:0] rx_word;
    logic        rx_err, rx_done;

    logic        direct;
    logic        d_vld;
    logic [15:0] d_word;
    logic [15:0] flip;
    logic [15:0] dl_word [LAT];
    logic        dl_vld  [LAT];

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        dl_word[0] <= tx_word;
        dl_vld[0]  <= tx_word_vld;
        for (int i = 1; i < LAT; i++) begin
            dl_word[i] <= dl_word[i-1];
            dl_vld[i]  <= dl_vld[i-1];
        end
    end

    assign rx_vld  = direct ? d_vld  : dl_vld[LAT-1];
    assign rx_word = direct ? d_word : (dl_word[LAT-1] ^ flip);

    incr_bist uut (
        .tx_clk(clk), .tx_rst(tx_rst), .tx_en(tx_en),
        .tx_word(tx_word), .tx_word_vld(tx_word_vld),
        .rx_clk(clk), .rx_rst(rx_rst), .rx_vld(rx_vld),
        .rx_word(rx_word), .rx_err(rx_err), .rx_done(rx_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input logic [7:0] n);
        return {n + 8'd1, n};
    endfunction

    task automatic reset_all();
        @(negedge clk);
        tx_rst = 1'b1; rx_rst = 1'b1; tx_en = 1'b0;
        d_vld = 1'b0; d_word = '0; flip = '0;
        repeat (3) @(negedge clk);
        tx_rst = 1'b0; rx_rst = 1'b0;
    endtask

    task automatic push(input logic v, input logic [15:0] w);
        d_vld = v; d_word = w;
        @(negedge clk);
    endtask

    task automatic t_reset();
        direct = 1'b1;
        reset_all();
        check("R1 tx_word_vld", 32'(tx_word_vld), 0);
        check("R1 rx_err", 32'(rx_err), 0);
        check("R1 rx_done", 32'(rx_done), 0);
    endtask

    task automatic t_gen();
        logic [7:0] n = 8'd0;
        logic prev = 1'b0;
        direct = 1'b1;
        reset_all();
        for (int k = 0; k < 320; k++) begin
            if (prev) begin
                check("R2/R3 vld", 32'(tx_word_vld), 1);
                check("R2/R3 word", 32'(tx_word), 32'(pat(n)));
                n = n + 8'd2;
            end else begin
                check("R2 idle vld", 32'(tx_word_vld), 0);
            end
            prev = (k % 7) != 3;
            tx_en = prev;
            @(negedge clk);
        end
        tx_en = 1'b0;
    endtask

    task automatic t_boundary();
        direct = 1'b1;
        reset_all();
        push(1'b1, 16'h1234);
        push(1'b1, 16'h0302);
        push(1'b1, 16'h0001);
        check("R4 err before lock", 32'(rx_err), 0);
        check("R4 done before lock", 32'(rx_done), 0);
        for (int k = 0; k < 127; k++) begin
            push(1'b1, pat(8'(2*k)));
            if (k % 5 == 2) push(1'b0, 16'hDEAD);
        end
        check("R5/R7 done after 127", 32'(rx_done), 0);
        push(1'b1, 16'hFFFE);
        check("R5 done after 128", 32'(rx_done), 1);
        check("R5 err clean", 32'(rx_err), 0);
        push(1'b1, 16'hBAD0);
        push(1'b1, 16'h0000);
        check("R8 late mismatch err", 32'(rx_err), 0);
        check("R8 done held", 32'(rx_done), 1);
        push(1'b0, 16'h0);
    endtask

    task automatic t_mismatch();
        direct = 1'b1;
        reset_all();
        push(1'b1, 16'h0100);
        for (int k = 1; k < 6; k++) push(1'b1, pat(8'(2*k)));
        check("R6 err before bad", 32'(rx_err), 0);
        push(1'b1, 16'h0E0D);
        check("R6 err set", 32'(rx_err), 1);
        check("R6 done set", 32'(rx_done), 1);
        for (int k = 0; k < 4; k++) push(1'b1, pat(8'(2*k)));
        check("R6 err sticky", 32'(rx_err), 1);
        check("R6 done sticky", 32'(rx_done), 1);
        push(1'b0, 16'h0);
    endtask

    task automatic t_loop();
        direct = 1'b0;
        reset_all();
        tx_en = 1'b1;
        repeat (300) @(negedge clk);
        check("R5 loop done", 32'(rx_done), 1);
        check("R5 loop err", 32'(rx_err), 0);
        reset_all();
        tx_en = 1'b1;
        repeat (40) @(negedge clk);
        flip = 16'h0008;
        @(negedge clk);
        flip = '0;
        @(negedge clk);
        check("R6 injected err", 32'(rx_err), 1);
        check("R6 injected done", 32'(rx_done), 1);
        rx_rst = 1'b1;
        @(negedge clk);
        check("R9 rx reset clears err", 32'(rx_err), 0);
        check("R9 rx reset clears done", 32'(rx_done), 0);
        check("R9 gen runs through rx reset", 32'(tx_word_vld), 1);
        rx_rst = 1'b0;
        repeat (300) @(negedge clk);
        check("R9 relock done", 32'(rx_done), 1);
        check("R9 relock err", 32'(rx_err), 0);
        tx_rst = 1'b1;
        @(negedge clk);
        check("R1 tx reset vld", 32'(tx_word_vld), 0);
        check("R9 tx reset keeps done", 32'(rx_done), 1);
        check("R9 tx reset keeps err", 32'(rx_err), 0);
        tx_rst = 1'b0; tx_en = 1'b0;
    endtask

    initial begin
        direct = 1'b1; tx_rst = 1'b1; rx_rst = 1'b1; tx_en = 1'b0;
        d_vld = 1'b0; d_word = '0; flip = '0;
        t_reset();
        t_gen();
        t_boundary();
        t_mismatch();
        t_loop();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule